// File: doc/BRIEF.md
# Three-Multiplier Complex Multiplier

This block multiplies a complex data sample by a complex coefficient using three real multipliers instead of four. The data sample (a + jb) and coefficient (c + jd) each arrive as 18-bit two's-complement real and imaginary parts. The coefficient is read as a signed fraction with 17 fractional bits, so the product is brought back to the data scale before it leaves the block.

The factored form computes one product, a(c - d), only once and uses it in both output lanes. The real result is a(c - d) + d(a - b) and the imaginary result is c(a + b) - a(c - d). This costs three extra adders in place of one multiplier.

The pipeline has three stages: a pre-adder stage, a multiply stage and a sum/round/saturate stage. Inputs are captured only when the input valid strobe is high. Output results appear exactly three clock edges later. Samples may be presented on every cycle or with gaps.

Top module: `cplx_mul3`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and p_re_o and p_im_o are 0.
- R2: out_valid_o is high exactly three rising edges after the edge at which in_valid_i was sampled high, and low otherwise.
- R3: For a sample with data (a, b) and coefficient (c, d), p_re_o equals sat(rnd(a*c - b*d)). All values are two's-complement integers.
- R4: For the same sample, p_im_o equals sat(rnd(a*d + b*c)). When both b and d are 0, p_im_o is 0.
- R5: rnd(x) is floor((x + 2^16) / 2^17). This divides by the coefficient scale and rounds halves toward positive infinity. For example, 65536 gives 1 and -65536 gives 0.
- R6: sat clamps values above 131071 to 131071 and values below -131072 to -131072. Each lane saturates independently.
- R7: While out_valid_o is low, p_re_o and p_im_o keep the values of the last valid result. Inputs presented with in_valid_i low have no effect on the outputs.
- R8: A new sample is accepted on every cycle that in_valid_i is high. Back-to-back samples produce back-to-back results in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| a_re_i | input | 18 | Data real part (a) |
| a_im_i | input | 18 | Data imaginary part (b) |
| c_re_i | input | 18 | Coefficient real part (c), 17 fraction bits |
| c_im_i | input | 18 | Coefficient imaginary part (d), 17 fraction bits |
| out_valid_o | output | 1 | Result strobe |
| p_re_o | output | 18 | Product real part |
| p_im_o | output | 18 | Product imaginary part |

## Verification
Rounding and saturation are applied to both lanes in the same cycle, and each lane takes the shared product with the opposite sign. One lane can therefore clamp while the other rounds an ordinary small value. The bench provokes this with full-scale directed operands, for example a = b = c = -131072 with d = 131071. There the real lane clamps to 131071 while the imaginary lane lands on 1. The same vectors are also sent back-to-back with random traffic. Each lane is judged separately against a direct four-multiply reference computed in the bench with 64-bit integers, using the same round-half-up and clamp rules.

// File: rtl/cplx_mul3_pkg.sv
package cplx_mul3_pkg;
  // lanes of the multiply stage
  typedef enum int {
    LANE_SH = 0,  // a * (c - d), shared
    LANE_RE = 1,  // d * (a - b)
    LANE_IM = 2   // c * (a + b)
  } lane_e;
  localparam int NUM_LANES = 3;
endpackage

// File: rtl/cplx_mul3_preadd.sv
module cplx_mul3_preadd #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  localparam int PRE_W = ((DATA_W > COEF_W) ? DATA_W : COEF_W) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [COEF_W-1:0] c_i,
  input  logic signed [COEF_W-1:0] d_i,
  output logic                     vld_o,
  output logic signed [DATA_W-1:0] a_o,
  output logic signed [COEF_W-1:0] c_o,
  output logic signed [COEF_W-1:0] d_o,
  output logic signed [PRE_W-1:0]  cmd_o,
  output logic signed [PRE_W-1:0]  amb_o,
  output logic signed [PRE_W-1:0]  apb_o
);
  logic signed [PRE_W-1:0] cmd_d, amb_d, apb_d;

  // one guard bit: sums of two full-scale operands never wrap
  assign cmd_d = PRE_W'(c_i) - PRE_W'(d_i);
  assign amb_d = PRE_W'(a_i) - PRE_W'(b_i);
  assign apb_d = PRE_W'(a_i) + PRE_W'(b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      a_o   <= '0;
      c_o   <= '0;
      d_o   <= '0;
      cmd_o <= '0;
      amb_o <= '0;
      apb_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        a_o   <= a_i;
        c_o   <= c_i;
        d_o   <= d_i;
        cmd_o <= cmd_d;
        amb_o <= amb_d;
        apb_o <= apb_d;
      end
    end
  end
endmodule

// File: rtl/cplx_mul3_mult.sv
module cplx_mul3_mult #(
  parameter int X_W = 18,
  parameter int Y_W = 19,
  localparam int P_W = X_W + Y_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic signed [X_W-1:0] x_i,
  input  logic signed [Y_W-1:0] y_i,
  output logic signed [P_W-1:0] p_o
);
  logic signed [P_W-1:0] x_ext, y_ext, p_d;

  assign x_ext = P_W'(x_i);
  assign y_ext = P_W'(y_i);
  assign p_d   = x_ext * y_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= p_d;
  end
endmodule

// File: rtl/cplx_mul3_post.sv
module cplx_mul3_post #(
  parameter int PROD_W = 37,
  parameter int FRAC_W = 17,
  parameter int OUT_W  = 18,
  localparam int SUM_W = PROD_W + 1,
  localparam int RND_W = SUM_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [PROD_W-1:0] sh_i,
  input  logic signed [PROD_W-1:0] pr_i,
  input  logic signed [PROD_W-1:0] pi_i,
  output logic                    vld_o,
  output logic signed [OUT_W-1:0] re_o,
  output logic signed [OUT_W-1:0] im_o
);
  localparam logic signed [RND_W-1:0] HALF    = RND_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [RND_W-1:0] MAX_VAL = (RND_W'(1) <<< (OUT_W - 1)) - RND_W'(1);
  localparam logic signed [RND_W-1:0] MIN_VAL = -(RND_W'(1) <<< (OUT_W - 1));

  logic signed [SUM_W-1:0] sum [2];
  logic signed [OUT_W-1:0] res [2];

  assign sum[0] = SUM_W'(sh_i) + SUM_W'(pr_i);
  assign sum[1] = SUM_W'(pi_i) - SUM_W'(sh_i);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [RND_W-1:0] rnd, shf;
    assign rnd = RND_W'(sum[g]) + HALF;
    assign shf = rnd >>> FRAC_W;
    always_comb begin
      if (shf > MAX_VAL)      res[g] = MAX_VAL[OUT_W-1:0];
      else if (shf < MIN_VAL) res[g] = MIN_VAL[OUT_W-1:0];
      else                    res[g] = shf[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      re_o  <= '0;
      im_o  <= '0;
    end else begin
      vld_o <= en_i;
      if (en_i) begin
        re_o <= res[0];
        im_o <= res[1];
      end
    end
  end
endmodule

// File: rtl/cplx_mul3.sv
module cplx_mul3 #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  parameter int FRAC_W = COEF_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] a_re_i,
  input  logic [DATA_W-1:0] a_im_i,
  input  logic [COEF_W-1:0] c_re_i,
  input  logic [COEF_W-1:0] c_im_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] p_re_o,
  output logic [DATA_W-1:0] p_im_o
);
  import cplx_mul3_pkg::*;

  localparam int MAX_W  = (DATA_W > COEF_W) ? DATA_W : COEF_W;
  localparam int PRE_W  = MAX_W + 1;
  localparam int PROD_W = MAX_W + PRE_W;

  logic                    v1, v2;
  logic signed [DATA_W-1:0] a1;
  logic signed [COEF_W-1:0] c1, d1;
  logic signed [PRE_W-1:0]  cmd1, amb1, apb1;
  logic signed [MAX_W-1:0]  x_op [NUM_LANES];
  logic signed [PRE_W-1:0]  y_op [NUM_LANES];
  logic signed [PROD_W-1:0] prod [NUM_LANES];
  logic signed [DATA_W-1:0] re_s, im_s;

  cplx_mul3_preadd #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (in_valid_i),
    .a_i   ($signed(a_re_i)),
    .b_i   ($signed(a_im_i)),
    .c_i   ($signed(c_re_i)),
    .d_i   ($signed(c_im_i)),
    .vld_o (v1),
    .a_o   (a1),
    .c_o   (c1),
    .d_o   (d1),
    .cmd_o (cmd1),
    .amb_o (amb1),
    .apb_o (apb1)
  );

  assign x_op[LANE_SH] = MAX_W'(a1);
  assign y_op[LANE_SH] = cmd1;
  assign x_op[LANE_RE] = MAX_W'(d1);
  assign y_op[LANE_RE] = amb1;
  assign x_op[LANE_IM] = MAX_W'(c1);
  assign y_op[LANE_IM] = apb1;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_mul
    cplx_mul3_mult #(.X_W(MAX_W), .Y_W(PRE_W)) u_mul (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (v1),
      .x_i   (x_op[l]),
      .y_i   (y_op[l]),
      .p_o   (prod[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v2 <= 1'b0;
    else         v2 <= v1;
  end

  cplx_mul3_post #(.PROD_W(PROD_W), .FRAC_W(FRAC_W), .OUT_W(DATA_W)) u_post (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (v2),
    .sh_i  (prod[LANE_SH]),
    .pr_i  (prod[LANE_RE]),
    .pi_i  (prod[LANE_IM]),
    .vld_o (out_valid_o),
    .re_o  (re_s),
    .im_o  (im_s)
  );

  assign p_re_o = re_s;
  assign p_im_o = im_s;
endmodule

// File: rtl/cplx_mul3_chk.sv
module cplx_mul3_chk #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] a_im_i,
  input logic [COEF_W-1:0] c_re_i,
  input logic [COEF_W-1:0] c_im_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] p_re_o,
  input logic [DATA_W-1:0] p_im_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset: assert (!out_valid_o && p_re_o == '0 && p_im_o == '0);
    end
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !out_valid_o) |-> ($stable(p_re_o) && $stable(p_im_o)));

  a_r4_real_axis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && out_valid_o && $past(a_im_i, 3) == '0 && $past(c_im_i, 3) == '0)
    |-> (p_im_o == '0));

  a_r3_zero_coef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && out_valid_o && $past(c_re_i, 3) == '0 && $past(c_im_i, 3) == '0)
    |-> (p_re_o == '0 && p_im_o == '0));
endmodule

bind cplx_mul3 cplx_mul3_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .a_im_i     (a_im_i),
  .c_re_i     (c_re_i),
  .c_im_i     (c_im_i),
  .out_valid_o(out_valid_o),
  .p_re_o     (p_re_o),
  .p_im_o     (p_im_o)
);

// File: tb/cplx_mul3_test.sv
module cplx_mul3_test;
  localparam int W = 18;
  localparam int QD = 4096;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] a_re_i = '0, a_im_i = '0, c_re_i = '0, c_im_i = '0;
  logic         out_valid_o;
  logic [W-1:0] p_re_o, p_im_o;

  cplx_mul3 uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .c_re_i(c_re_i), .c_im_i(c_im_i),
    .out_valid_o(out_valid_o), .p_re_o(p_re_o), .p_im_o(p_im_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run = 1'b0, done = 1'b0;
  logic [W-1:0] exp_re [QD];
  logic [W-1:0] exp_im [QD];
  int           exp_cyc [QD];
  string        exp_tag [QD];
  int head = 0, tail = 0;
  logic [W-1:0] last_re = '0, last_im = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // round half up by 2^17, then clamp to 18-bit signed
  function automatic logic [W-1:0] scale(input longint v);
    longint r;
    r = (v + 64'sd65536) >>> 17;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return r[W-1:0];
  endfunction

  task automatic drive(input longint a, input longint b, input longint c, input longint d,
                       input string tag);
    @(negedge clk_i);
    a_re_i = a[W-1:0]; a_im_i = b[W-1:0]; c_re_i = c[W-1:0]; c_im_i = d[W-1:0];
    in_valid_i = 1'b1;
    exp_re[tail % QD]  = scale(a * c - b * d);
    exp_im[tail % QD]  = scale(a * d + b * c);
    exp_cyc[tail % QD] = cyc + 3;
    exp_tag[tail % QD] = tag;
    tail++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      a_re_i = W'($urandom); a_im_i = W'($urandom);
      c_re_i = W'($urandom); c_im_i = W'($urandom);
    end
  endtask

  function automatic longint rnd_val();
    int unsigned k;
    k = $urandom % 8;
    case (k)
      0: return -131072;
      1: return 131071;
      2: return 0;
      default: return longint'($signed(W'($urandom)));
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (run && rst_ni) begin
      if (out_valid_o) begin
        if (head == tail) begin
          chk(1'b0, $sformatf("R2 unexpected out_valid act=1 exp=0 cyc=%0d", cyc));
        end else begin
          chk(exp_cyc[head % QD] == cyc,
              $sformatf("R2 latency %s act_cyc=%0d exp_cyc=%0d", exp_tag[head % QD],
                        cyc, exp_cyc[head % QD]));
          chk(p_re_o == exp_re[head % QD],
              $sformatf("R3 real %s act=%0d exp=%0d", exp_tag[head % QD],
                        $signed(p_re_o), $signed(exp_re[head % QD])));
          chk(p_im_o == exp_im[head % QD],
              $sformatf("R4 imag %s act=%0d exp=%0d", exp_tag[head % QD],
                        $signed(p_im_o), $signed(exp_im[head % QD])));
          head++;
        end
        last_re <= p_re_o;
        last_im <= p_im_o;
      end else begin
        if (head != tail && exp_cyc[head % QD] == cyc)
          chk(1'b0, $sformatf("R2 missing out_valid act=0 exp=1 cyc=%0d", cyc));
        chk(p_re_o == last_re && p_im_o == last_im,
            $sformatf("R7 hold act=%0d/%0d exp=%0d/%0d", $signed(p_re_o), $signed(p_im_o),
                      $signed(last_re), $signed(last_im)));
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0 && p_re_o == '0 && p_im_o == '0,
        $sformatf("R1 reset act=%0d/%0d/%0d exp=0/0/0", out_valid_o,
                  $signed(p_re_o), $signed(p_im_o)));
    rst_ni = 1'b1;
    run = 1'b1;
    idle(3);
    // R5 rounding at exact halves
    drive(1, 0, 65536, 0, "R5 +half");
    drive(-1, 0, 65536, 0, "R5 -half");
    drive(3, 0, 65536, 0, "R5 1.5");
    drive(-3, 0, 65536, 0, "R5 -1.5");
    idle(4);
    // R6 clamping, one lane or both
    drive(-131072, 0, -131072, 0, "R6 re max");
    drive(-131072, -131072, -131072, 131071, "R6 re max im small");
    drive(-131072, -131072, -131072, -131072, "R6 im max");
    drive(131071, 131071, -131072, 131071, "R6 re min");
    drive(131071, -131072, 131071, 131071, "R6 mixed");
    drive(1000, -2000, 0, 0, "R3 zero coef");
    drive(-5000, 0, 70000, 0, "R4 real axis");
    idle(5);
    // R8 back-to-back random burst
    for (int i = 0; i < 400; i++) drive(rnd_val(), rnd_val(), rnd_val(), rnd_val(), "R8 burst");
    // random traffic with gaps (R7 between samples)
    for (int i = 0; i < 1200; i++) begin
      drive(rnd_val(), rnd_val(), rnd_val(), rnd_val(), "R3 random");
      if ($urandom % 3 == 0) idle(1 + $urandom % 4);
    end
    idle(6);
    chk(head == tail, $sformatf("R2 drained act=%0d exp=%0d", head, tail));
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule